// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Error Tags

This block buffers characters coming out of a serial deserializer on the receive side of a 16550-compatible UART. Each character is stored together with three tag bits (parity error, framing error, break) so that a fault is reported only when the faulty character reaches the head of the queue. The CPU reads the oldest character through `head_data`. It watches `lsr`, an 8-bit line status word, and takes an interrupt request on `lsi_req` whenever the head character carries a tag or characters have been lost.

The queue runs in two modes. With `fifo_en` high it holds up to `DEPTH` entries. With `fifo_en` low it behaves as a single holding register. Every collision is resolved within one cycle: a push that meets a receive-buffer read, or a push that meets a status read. No tag is lost and no overrun is reported when none occurred.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `lsr` is 0, `lsi_req` is 0 and `head_data` is 0.
- R2: Characters leave in the order they were accepted. While the queue is non-empty, `head_data` shows the oldest character. While it is empty, `head_data` is 0.
- R3: In `lsr`, bit 2 is the parity flag, bit 3 the framing flag and bit 4 the break flag. Each becomes 1 in the cycle after a character carrying that tag becomes the head. It then stays 1 until a status read.
- R4: A status read (`lsr_rd`) clears bits 1 to 4 at the following edge. If a flag is set in the same cycle, for example a tagged character pushed into an empty queue, the flag is set and not cleared.
- R5: `lsr` bit 0 (data ready) is 1 exactly while the queue holds a character. A push in the same cycle as a read of the last character keeps bit 0 at 1 and does not set the overrun flag.
- R6: With `fifo_en` high, a push into a full queue without a read in the same cycle is discarded and sets `lsr` bit 1 (overrun). A push into a full queue together with a read is accepted and does not set the overrun flag.
- R7: With `fifo_en` low, the capacity is one character. A push while that character is unread sets the overrun flag, and the new character replaces the old one together with its tags.
- R8: `lsr` bit 7 is 1 exactly when `fifo_en` is high and at least one stored character carries a tag. Bits 5 and 6 are always 0.
- R9: `lsi_req` is 1 exactly when any of `lsr` bits 1 to 4 is 1.
- R10: In a cycle where `fifo_en` differs from its value in the previous cycle (taken as 0 at reset), the queue is emptied, and any push or receive-buffer read in that cycle is ignored.
- R11: A receive-buffer read of an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: deep queue mode, 0: single holding register |
| push_valid | input | 1 | Deserializer offers a character this cycle |
| push_data | input | DATA_W | Received character |
| push_perr | input | 1 | Parity error tag of the character |
| push_ferr | input | 1 | Framing error tag of the character |
| push_brk | input | 1 | Break tag of the character |
| rbr_rd | input | 1 | CPU read of the receive buffer (pops the head) |
| lsr_rd | input | 1 | CPU read of the line status word |
| head_data | output | DATA_W | Oldest stored character, 0 when empty |
| lsr | output | 8 | Line status: bit 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 7 any tagged entry |
| lsi_req | output | 1 | Line status interrupt request |

## Verification
The hardest situations to reach are the single-cycle collisions at the queue boundaries: a push meeting a read of the last character, a push into a full queue meeting a read, and a tagged push into an empty queue meeting a status read. Directed sequences fill the queue to exactly one entry and to exactly `DEPTH` entries, then apply each collision in one cycle. A long random phase follows, with dense push and read strobes and occasional mode changes, checked every cycle against a queue model in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Tag bits stored alongside every character; brk sits in the MSB.
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_tags_t;

  localparam int TAG_W = 3;

  // Status word bit positions (decoded by software, so fixed).
  localparam int ST_READY = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_ANY   = 7;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            wr,
  input  logic                            rd,
  input  logic                            ovw,
  input  logic [DATA_W+rxq_pkg::TAG_W-1:0] wentry,
  output logic [DATA_W+rxq_pkg::TAG_W-1:0] head,
  output logic [DATA_W+rxq_pkg::TAG_W-1:0] nxt,
  output logic [$clog2(DEPTH+1)-1:0]       count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + rxq_pkg::TAG_W;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, rd_ptr_nx, wr_ptr, wr_ptr_nx, rd_inc;
  logic [CW-1:0] cnt_nx;
  logic          ptr_en;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign rd_inc = bump(rd_ptr);

  always_comb begin
    rd_ptr_nx = rd_ptr;
    wr_ptr_nx = wr_ptr;
    cnt_nx    = count;
    if (clr) begin
      rd_ptr_nx = '0;
      wr_ptr_nx = '0;
      cnt_nx    = '0;
    end else begin
      if (rd) rd_ptr_nx = rd_inc;
      if (wr) wr_ptr_nx = bump(wr_ptr);
      case ({wr, rd})
        2'b10:   cnt_nx = count + CW'(1);
        2'b01:   cnt_nx = count - CW'(1);
        default: cnt_nx = count;
      endcase
    end
  end

  assign ptr_en = clr | wr | rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (ptr_en) begin
      rd_ptr <= rd_ptr_nx;
      wr_ptr <= wr_ptr_nx;
      count  <= cnt_nx;
    end
  end

  // Storage array: no reset, written only under an explicit enable.
  always_ff @(posedge clk) begin
    if (wr && !clr) begin
      mem[wr_ptr] <= wentry;
    end else if (ovw && !clr) begin
      mem[rd_ptr] <= wentry;
    end
  end

  assign head = mem[rd_ptr];
  assign nxt  = mem[rd_inc];

endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int CW = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          lsr_rd,
  input  logic                          set_ovr,
  input  logic                          head_new,
  input  logic [rxq_pkg::TAG_W-1:0]     new_tags,
  input  logic                          inc,
  input  logic                          dec,
  output logic                          ovr,
  output logic [rxq_pkg::TAG_W-1:0]     sticky,
  output logic                          err_any
);

  logic [CW-1:0] err_cnt, err_cnt_nx;
  logic          ovr_nx;
  logic          cnt_en;

  // One sticky bit per tag: set by a new head carrying it, cleared by a
  // status read; setting wins over clearing.
  for (genvar g = 0; g < rxq_pkg::TAG_W; g++) begin : g_tag
    logic bit_nx;
    always_comb begin
      bit_nx = sticky[g];
      if (lsr_rd)                 bit_nx = 1'b0;
      if (head_new && new_tags[g]) bit_nx = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky[g] <= 1'b0;
      else        sticky[g] <= bit_nx;
    end
  end

  always_comb begin
    ovr_nx = ovr;
    if (lsr_rd)  ovr_nx = 1'b0;
    if (set_ovr) ovr_nx = 1'b1;
  end

  always_comb begin
    err_cnt_nx = err_cnt;
    if (clr) begin
      err_cnt_nx = '0;
    end else begin
      case ({inc, dec})
        2'b10:   err_cnt_nx = err_cnt + CW'(1);
        2'b01:   err_cnt_nx = err_cnt - CW'(1);
        default: err_cnt_nx = err_cnt;
      endcase
    end
  end

  assign cnt_en = clr | inc | dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr     <= 1'b0;
      err_cnt <= '0;
    end else begin
      ovr <= ovr_nx;
      if (cnt_en) err_cnt <= err_cnt_nx;
    end
  end

  assign err_any = (err_cnt != '0);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              rbr_rd,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] head_data,
  output logic [7:0]        lsr,
  output logic              lsi_req
);

  import rxq_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + TAG_W;

  logic          en_q, mode_chg;
  logic [CW-1:0] count, cap;
  logic [EW-1:0] head, nxt, wentry;
  logic          empty, full, pop, pv, acc, ovr_ev, ovw, head_new;
  rxq_tags_t     in_tags, head_tags, nxt_tags, new_tags;
  logic          inc, dec;
  logic          ovr;
  logic [TAG_W-1:0] sticky;
  logic          err_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign mode_chg = fifo_en ^ en_q;
  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign in_tags  = '{brk: push_brk, ferr: push_ferr, perr: push_perr};
  assign wentry   = {in_tags, push_data};
  assign head_tags = head[EW-1 -: TAG_W];
  assign nxt_tags  = nxt[EW-1 -: TAG_W];

  always_comb begin
    empty  = (count == '0);
    full   = (count >= cap);
    pop    = rbr_rd & ~empty & ~mode_chg;
    pv     = push_valid & ~mode_chg;
    acc    = pv & (~full | pop);
    ovr_ev = pv & full & ~pop;
    ovw    = ovr_ev & ~fifo_en;
    head_new = (acc & (empty | (pop & (count == CW'(1)))))
             | (pop & (count > CW'(1)))
             | ovw;
    new_tags = (pop && count > CW'(1)) ? nxt_tags : in_tags;
    inc = (acc | ovw) & (|in_tags);
    dec = (pop | ovw) & (|head_tags);
  end

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mode_chg),
    .wr     (acc),
    .rd     (pop),
    .ovw    (ovw),
    .wentry (wentry),
    .head   (head),
    .nxt    (nxt),
    .count  (count)
  );

  rxq_status #(.CW(CW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mode_chg),
    .lsr_rd   (lsr_rd),
    .set_ovr  (ovr_ev),
    .head_new (head_new),
    .new_tags (new_tags),
    .inc      (inc),
    .dec      (dec),
    .ovr      (ovr),
    .sticky   (sticky),
    .err_any  (err_any)
  );

  always_comb begin
    lsr           = '0;
    lsr[ST_READY] = ~empty;
    lsr[ST_OVR]   = ovr;
    lsr[ST_PAR]   = sticky[0];
    lsr[ST_FRM]   = sticky[1];
    lsr[ST_BRK]   = sticky[2];
    lsr[ST_ANY]   = fifo_en & err_any;
  end

  assign head_data = empty ? '0 : head[DATA_W-1:0];
  assign lsi_req   = ovr | (|sticky);

endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_en,
  input logic              push_valid,
  input logic              push_perr,
  input logic              rbr_rd,
  input logic              lsr_rd,
  input logic [DATA_W-1:0] head_data,
  input logic [7:0]        lsr,
  input logic              lsi_req
);

  logic en_seen;
  logic steady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= 1'b0;
    else        en_seen <= fifo_en;
  end

  assign steady = (fifo_en == en_seen);

  // R5: push meeting a read of a present character keeps ready, no overrun
  a_r5_collide_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && lsr[0] && rbr_rd && push_valid && (lsr_rd || !lsr[1]))
    |=> (lsr[0] && !lsr[1]));

  // R4: tagged push into an empty queue survives a same-cycle status read
  a_r4_tag_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && !lsr[0] && push_valid && push_perr && lsr_rd)
    |=> (lsr[2] && lsi_req));

  // R11: reading an empty queue leaves it empty
  a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr[0] && rbr_rd && !push_valid) |=> !lsr[0]);

  // R8: summary flag only with deep mode and stored data
  a_r8_summary: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[7] |-> (lsr[0] && fifo_en));

  // R2: empty queue presents zero
  a_r2_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> (head_data == '0));

  // R7: holding register overrun keeps a character present
  a_r7_hold_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && !fifo_en && lsr[0] && push_valid && !rbr_rd)
    |=> (lsr[1] && lsr[0]));

  // R9: interrupt request accompanies a raised status flag
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsi_req) |-> (|lsr[4:1]));

endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .push_valid (push_valid),
  .push_perr  (push_perr),
  .rbr_rd     (rbr_rd),
  .lsr_rd     (lsr_rd),
  .head_data  (head_data),
  .lsr        (lsr),
  .lsi_req    (lsi_req)
);

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic       push_valid;
  logic [7:0] push_data;
  logic       push_perr, push_ferr, push_brk;
  logic       rbr_rd, lsr_rd;
  logic [7:0] head_data;
  logic [7:0] lsr;
  logic       lsi_req;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  rx_err_fifo #(.DEPTH(16), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
    .push_data(push_data), .push_perr(push_perr), .push_ferr(push_ferr),
    .push_brk(push_brk), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .head_data(head_data), .lsr(lsr), .lsi_req(lsi_req)
  );

  // Reference queue: entry = {brk, ferr, perr, data}
  logic [10:0] mq[$];
  bit       m_ovr;
  bit [2:0] m_st;
  bit       en_prev;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit any;
    any = 0;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) any = 1;
    chk("R5 ready", int'(lsr[0]), int'(mq.size() != 0));
    chk("R6 R7 overrun", int'(lsr[1]), int'(m_ovr));
    chk("R3 tag flags", int'(lsr[4:2]), int'(m_st));
    chk("R8 summary", int'(lsr[7]), int'(fifo_en && any));
    chk("R8 unused bits", int'(lsr[6:5]), 0);
    chk("R2 head", int'(head_data), (mq.size() != 0) ? int'(mq[0][7:0]) : 0);
    chk("R9 irq", int'(lsi_req), int'(m_ovr || (m_st != 0)));
  endtask

  task automatic cyc(bit pv, bit [7:0] d, bit [2:0] f, bit rr, bit lr);
    bit chg, pop, full, acc, ovr, wasempty, hn;
    int cap;
    push_valid = pv; push_data = d;
    {push_brk, push_ferr, push_perr} = f;
    rbr_rd = rr; lsr_rd = lr;
    chg = (fifo_en != en_prev);
    hn = 0;
    if (lr) begin m_ovr = 0; m_st = 0; end
    if (chg) begin
      mq.delete();
    end else begin
      cap = fifo_en ? 16 : 1;
      wasempty = (mq.size() == 0);
      pop  = rr && !wasempty;
      full = (mq.size() >= cap);
      acc  = pv && (!full || pop);
      ovr  = pv && full && !pop;
      if (pop) begin void'(mq.pop_front()); hn = 1; end
      if (acc) mq.push_back({f, d});
      if (ovr && !fifo_en) begin mq[0] = {f, d}; hn = 1; end
      if (acc && wasempty) hn = 1;
      if (mq.size() == 0) hn = 0;
      if (ovr) m_ovr = 1;
      if (hn) m_st = m_st | mq[0][10:8];
    end
    en_prev = fifo_en;
    @(posedge clk); #1;
    push_valid = 0; rbr_rd = 0; lsr_rd = 0;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; fifo_en = 0; push_valid = 0; push_data = 0;
    push_perr = 0; push_ferr = 0; push_brk = 0; rbr_rd = 0; lsr_rd = 0;
    en_prev = 0; m_ovr = 0; m_st = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset lsr", int'(lsr), 0);
    chk("R1 reset irq", int'(lsi_req), 0);
    chk("R1 reset head", int'(head_data), 0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0);

    // R11: read of empty holding register
    cyc(0, 0, 0, 1, 0);
    chk("R11 empty read", int'(lsr[0]), 0);

    // Holding mode: every tag pattern, push, overrun, status read, pop
    for (int t = 0; t < 8; t++) begin
      cyc(1, 8'(8'h10 + t), 3'(t), 0, 0);
      cyc(1, 8'(8'h20 + t), 3'(7 - t), 0, 0);
      chk("R7 replaced", int'(head_data), 8'h20 + t);
      chk("R7 overrun", int'(lsr[1]), 1);
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 1, 0);
    end

    // R5: push meets read of the only character
    cyc(1, 8'h33, 3'b000, 0, 0);
    cyc(1, 8'h44, 3'b001, 1, 0);
    chk("R5 ready kept", int'(lsr[0]), 1);
    chk("R5 no overrun", int'(lsr[1]), 0);
    cyc(0, 0, 0, 1, 1);

    // R10: mode change ignores push
    fifo_en = 1;
    cyc(1, 8'h55, 3'b111, 0, 0);
    chk("R10 push ignored", int'(lsr[0]), 0);

    // Fill to full, overflow, full collision, drain with status reads
    for (int i = 0; i < 16; i++) cyc(1, 8'(i + 1), 3'(i % 8), 0, 0);
    cyc(1, 8'hEE, 3'b000, 0, 0);
    chk("R6 discarded overrun", int'(lsr[1]), 1);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 8'hF0, 3'b010, 1, 0);
    chk("R6 full collision", int'(lsr[1]), 0);
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 1, (i % 2) == 0);
    cyc(0, 0, 0, 0, 1);

    // R4: tagged push into empty queue with same-cycle status read
    for (int t = 1; t < 8; t++) begin
      cyc(1, 8'(8'h60 + t), 3'(t), 0, 1);
      chk("R4 tag kept", int'(lsr[4:2]), t);
      cyc(0, 0, 0, 1, 1);
    end

    // R10: leaving deep mode with data present flushes it
    for (int i = 0; i < 5; i++) cyc(1, 8'(8'h80 + i), 3'b100, 0, 0);
    fifo_en = 0;
    cyc(0, 0, 0, 0, 0);
    chk("R10 flush", int'(lsr[0]), 0);

    // Dense random phase with occasional mode changes
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 300) == 0) fifo_en = ~fifo_en;
      cyc(($urandom % 4) != 0, 8'($urandom), 3'(($urandom % 3 == 0) ? $urandom : 0),
          ($urandom % 3) == 0, ($urandom % 5) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule